// File: doc/BRIEF.md
# SPI Serial Memory Slave with Write Protection

This block is a synthesizable SPI-mode-0 slave that behaves like a small serial byte memory. A single system clock samples the chip select, serial clock, serial input and write-protect pin through a synchronizer. The block then decodes an instruction byte and handles six commands:

- setting and clearing a write-enable latch;
- reading and writing a status register;
- sequential reads of the internal array;
- single-byte writes to the internal array.

The array size is set by a parameter. Every write is checked against a combined protection rule before it is committed:

- a two-bit block-protect level guards a region counted down from the top of the array;
- a protect-enable bit, together with a low write-protect pin, freezes the status register.

A committed write starts a busy timer of a parameterised length. It stands in for the internal programming cycle. While the timer runs, only the status-read command is served.

The serial link has no back-pressure. The master paces every bit with SCK, and the slave never stalls it. The master must keep each SCK phase longer than the synchronizer latency, and must poll the busy flag before issuing a new command. The control pins are plain levels.

Top module: `spi_mem_slave`

## Requirements
- R1: Op-code 0x03 followed by a 16-bit address (MSB first) makes SO return the addressed byte MSB first. Each data bit is updated after a falling SCK edge. SI is ignored after the address.
- R2: While CS stays low during a read, the address advances by one after each byte, and after the highest array address it wraps to 0.
- R3: A write (op-code 0x02, then 16-bit address, then data byte) or a status write (0x01, then data byte) has no effect and starts no busy period unless the write-enable latch is set.
- R4: Status bits 3:2 hold the block-protect level. 00 guards nothing, 01 guards the top quarter, 10 guards the top half, and 11 guards the whole array. A write to a guarded address changes nothing and starts no busy period.
- R5: Op-code 0x05 returns the status byte {protect-enable, 0, 0, 0, level[1], level[0], write-enable latch, busy}. The byte is repeated while CS stays low, and it reads 0x00 after reset.
- R6: When protect-enable (status bit 7) is 1 and the write-protect pin is low, status writes are rejected, so protect-enable cannot be cleared. Writes to unguarded array addresses still succeed.
- R7: When protect-enable is 0 or the write-protect pin is high, a status write with the latch set stores bit 7 and bits 3:2 of the data byte.
- R8: While busy, every command except 0x05 is ignored. A read started then returns only zeros.
- R9: A write is committed only when CS rises exactly on a byte boundary after a complete data byte. Busy then reads 1 for BUSY_CYCLES clocks, and the latch clears when busy ends.
- R10: Op-code 0x06 sets the write-enable latch, and op-code 0x04 clears it.
- R11: Address bits above the array width are ignored, so addresses that differ only there select the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples all SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low (mode 0) |
| si | input | 1 | Serial data from the master, sampled on rising SCK |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data to the master, changes after falling SCK |

## Verification
Each SCK or CS edge reaches the logic three clocks after it occurs: two synchronizer stages and one edge register. SO therefore settles about four clocks after a falling SCK edge. A commit happens about four clocks after CS rises, and busy shows one clock later. The bench holds every SCK phase for eight clocks and reads SO just before the next rising edge. It waits sixteen clocks after raising CS before selecting the device again. It polls the status about a hundred clocks into a busy period and again well after it has ended, so no sample falls near a transition.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [2:0] {
    ST_CMD, ST_ADH, ST_ADL, ST_RD, ST_WR, ST_SRW, ST_RDSR, ST_SKIP
  } spi_st_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

  // level: block-protect code; top2: two most significant array address bits
  function automatic logic blk_guarded(input logic [1:0] level, input logic [1:0] top2);
    case (level)
      2'b00:   blk_guarded = 1'b0;
      2'b01:   blk_guarded = (top2 == 2'b11);
      2'b10:   blk_guarded = top2[1];
      default: blk_guarded = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  output logic cs_s,
  output logic si_s,
  output logic wp_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  localparam int NSIG = 4;
  localparam logic [NSIG-1:0] RST_VAL = 4'b1001; // {cs_n, sck, si, wp_n}

  logic [STAGES-1:0][NSIG-1:0] pipe;
  logic sck_prev, cs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= {cs_n, sck, si, wp_n};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= RST_VAL;
      else        pipe[g] <= pipe[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      cs_prev  <= 1'b1;
    end else begin
      sck_prev <= pipe[STAGES-1][2];
      cs_prev  <= pipe[STAGES-1][3];
    end
  end

  assign cs_s     = pipe[STAGES-1][3];
  assign si_s     = pipe[STAGES-1][1];
  assign wp_s     = pipe[STAGES-1][0];
  assign sck_rise = pipe[STAGES-1][2] & ~sck_prev;
  assign sck_fall = ~pipe[STAGES-1][2] & sck_prev;
  assign cs_rise  = pipe[STAGES-1][3] & ~cs_prev;
endmodule

// File: rtl/spi_mem_prot.sv
module spi_mem_prot
  import spi_mem_pkg::*;
(
  input  logic [1:0] level,
  input  logic [1:0] top2,
  input  logic       wpen,
  input  logic       wp_s,
  input  logic       wel,
  output logic       hw_lock,
  output logic       arr_ok,
  output logic       sr_ok
);
  assign hw_lock = wpen & ~wp_s;
  assign arr_ok  = wel & ~blk_guarded(level, top2);
  assign sr_ok   = wel & ~hw_lock;
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  output logic so
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam int MSB = ADDR_W - 1;

  logic cs_s, si_s, wp_s, sck_rise, sck_fall, cs_rise;
  spi_mem_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
    .cs_s(cs_s), .si_s(si_s), .wp_s(wp_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
  );

  spi_st_e           state;
  logic [2:0]        bitcnt;
  logic [6:0]        rxsh;
  logic [7:0]        rx_byte, tx, addr_hi, pend_data, status, rdata;
  logic [ADDR_W-1:0] addr_q;
  logic              pend_v, pend_sr;
  logic              wel, wpen;
  logic [1:0]        bp;
  logic [BW-1:0]     busy_cnt;
  logic              busy, byte_done;
  logic              hw_lock, arr_ok, sr_ok, commit, mem_we;

  assign busy      = (busy_cnt != '0);
  assign rx_byte   = {rxsh, si_s};
  assign byte_done = sck_rise & ~cs_s & (bitcnt == 3'd7);
  assign status    = {wpen, 3'b000, bp, wel, busy};

  spi_mem_prot prot_i (
    .level(bp), .top2(addr_q[MSB:MSB-1]), .wpen(wpen), .wp_s(wp_s), .wel(wel),
    .hw_lock(hw_lock), .arr_ok(arr_ok), .sr_ok(sr_ok)
  );

  assign commit = cs_rise & pend_v & (bitcnt == 3'd0) & (pend_sr ? sr_ok : arr_ok);
  assign mem_we = commit & ~pend_sr;

  spi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) array_i (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(addr_q), .wdata(pend_data),
    .raddr(addr_q), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CMD;
      bitcnt    <= '0;
      rxsh      <= '0;
      tx        <= '0;
      addr_hi   <= '0;
      addr_q    <= '0;
      pend_data <= '0;
      pend_v    <= 1'b0;
      pend_sr   <= 1'b0;
      wel       <= 1'b0;
      wpen      <= 1'b0;
      bp        <= '0;
      busy_cnt  <= '0;
    end else begin
      if (busy) begin
        busy_cnt <= busy_cnt - BW'(1);
        if (busy_cnt == BW'(1)) wel <= 1'b0;
      end
      if (cs_s) begin
        state  <= ST_CMD;
        bitcnt <= '0;
        pend_v <= 1'b0;
      end else begin
        if (sck_rise) begin
          bitcnt <= bitcnt + 3'd1;
          rxsh   <= {rxsh[5:0], si_s};
        end
        if (byte_done) begin
          case (state)
            ST_CMD: begin
              if (busy && rx_byte != OP_RDSR) state <= ST_SKIP;
              else begin
                case (rx_byte)
                  OP_WREN: begin wel <= 1'b1; state <= ST_SKIP; end
                  OP_WRDI: begin wel <= 1'b0; state <= ST_SKIP; end
                  OP_RDSR: state <= ST_RDSR;
                  OP_WRSR: state <= ST_SRW;
                  OP_READ: begin pend_sr <= 1'b0; state <= ST_ADH; end
                  OP_WRIT: begin pend_sr <= 1'b1; state <= ST_ADH; end
                  default: state <= ST_SKIP;
                endcase
              end
            end
            ST_ADH: begin addr_hi <= rx_byte; state <= ST_ADL; end
            ST_ADL: begin
              addr_q <= ADDR_W'({addr_hi, rx_byte});
              // pend_sr temporarily marks a write command during the address
              state  <= pend_sr ? ST_WR : ST_RD;
              pend_sr <= 1'b0;
            end
            ST_WR: begin
              pend_v    <= 1'b1;
              pend_sr   <= 1'b0;
              pend_data <= rx_byte;
            end
            ST_SRW: begin
              pend_v    <= 1'b1;
              pend_sr   <= 1'b1;
              pend_data <= rx_byte;
              state     <= ST_SKIP;
            end
            default: ;
          endcase
        end
        if (sck_fall && (state == ST_RD || state == ST_RDSR)) begin
          if (bitcnt == 3'd0) begin
            if (state == ST_RD) begin
              tx     <= rdata;
              addr_q <= addr_q + ADDR_W'(1);
            end else begin
              tx <= status;
            end
          end else begin
            tx <= {tx[6:0], 1'b0};
          end
        end
      end
      if (commit) begin
        busy_cnt <= BW'(BUSY_CYCLES);
        if (pend_sr) begin
          wpen <= pend_data[7];
          bp   <= pend_data[3:2];
        end
      end
    end
  end

  assign so = ~cs_s & (state == ST_RD || state == ST_RDSR) & tx[7];

  // Busy can only start from a write made with the latch set
  p_wel_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  // Latch is clear once the busy period ends
  p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // Status bits frozen while busy
  p_sr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({wpen, bp}));
  // Hardware lock keeps protect-enable set and the level unchanged
  p_hw_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen && !wp_s) |=> (wpen && $stable(bp)));
  // No array write lands in a guarded region
  p_guarded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bp != 2'b11) && !(bp == 2'b10 && addr_q[MSB])
               && !(bp == 2'b01 && addr_q[MSB] && addr_q[MSB-1]));
endmodule

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb_top;
  localparam int BUSY = 600;
  localparam int H    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so;

  always #10 clk = ~clk;

  spi_mem_slave #(.ADDR_W(8), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n), .so(so)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [256];
  logic ref_wel = 1'b0, ref_wpen = 1'b0;
  logic [1:0] ref_bp = 2'b00;

  function automatic logic guarded(input logic [1:0] lv, input logic [7:0] a);
    case (lv)
      2'b00: return 1'b0;
      2'b01: return a[7:6] == 2'b11;
      2'b10: return a[7];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status(input logic b);
    return {ref_wpen, 3'b000, ref_bp, ref_wel, b};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic desel();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 7; i >= 8 - nb; i--) begin
      si = b[i];
      repeat (H) @(negedge clk);
      r[i] = so;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic op_simple(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, 8, r); desel();
    if (op == 8'h06) ref_wel = 1'b1;
    if (op == 8'h04) ref_wel = 1'b0;
  endtask

  task automatic op_rdsr(input string req, input logic exp_busy);
    logic [7:0] r;
    sel(); xfer(8'h05, 8, r);
    xfer(8'h00, 8, r); check(req, r, exp_status(exp_busy));
    xfer(8'h00, 8, r); check(req, r, exp_status(exp_busy));
    desel();
  endtask

  task automatic finish_busy(input logic started);
    if (started) begin
      repeat (BUSY + 50) @(negedge clk);
      ref_wel = 1'b0;
    end
  endtask

  task automatic op_write(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] r;
    logic ok;
    sel(); xfer(8'h02, 8, r); xfer(a[15:8], 8, r); xfer(a[7:0], 8, r); xfer(d, 8, r); desel();
    ok = ref_wel && !guarded(ref_bp, a[7:0]);
    if (ok) ref_mem[a[7:0]] = d;
    finish_busy(ok);
  endtask

  task automatic op_wrsr(input logic [7:0] d);
    logic [7:0] r;
    logic ok;
    sel(); xfer(8'h01, 8, r); xfer(d, 8, r); desel();
    ok = ref_wel && !(ref_wpen && !wp_n);
    if (ok) begin ref_wpen = d[7]; ref_bp = d[3:2]; end
    finish_busy(ok);
  endtask

  task automatic op_read(input string req, input logic [15:0] a, input int n);
    logic [7:0] r;
    logic [7:0] p;
    p = a[7:0];
    sel(); xfer(8'h03, 8, r); xfer(a[15:8], 8, r); xfer(a[7:0], 8, r);
    for (int k = 0; k < n; k++) begin
      xfer($urandom, 8, r);
      check(req, r, ref_mem[p]);
      p = p + 8'd1;
    end
    desel();
  endtask

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    op_rdsr("R5 reset status", 1'b0);
    check("R1 SO low when idle", {7'd0, so}, 8'h00);

    // R3: write without latch
    op_write(16'h0010, 8'h5A);
    op_read("R3 write without latch", 16'h0010, 1);
    op_rdsr("R3 no busy", 1'b0);

    // R10
    op_simple(8'h06); op_rdsr("R10 latch set", 1'b0);
    op_simple(8'h04); op_rdsr("R10 latch cleared", 1'b0);

    // R9 busy timing and latch clear, R1 readback
    op_simple(8'h06);
    sel(); xfer(8'h02, 8, r); xfer(8'h00, 8, r); xfer(8'h05, 8, r); xfer(8'h77, 8, r); desel();
    ref_mem[5] = 8'h77;
    op_rdsr("R9 busy after commit", 1'b1);
    // R8: read during busy ignored
    sel(); xfer(8'h03, 8, r); xfer(8'h00, 8, r); xfer(8'h05, 8, r); xfer(8'h00, 8, r); desel();
    check("R8 read ignored while busy", r, 8'h00);
    finish_busy(1'b1);
    op_rdsr("R9 latch cleared after busy", 1'b0);
    op_read("R1 readback", 16'h0005, 1);

    // R2 wrap
    op_simple(8'h06); op_write(16'h00FF, 8'hA1);
    op_simple(8'h06); op_write(16'h0000, 8'hB2);
    op_simple(8'h06); op_write(16'h0001, 8'hC3);
    op_read("R2 wrap", 16'h00FF, 3);

    // R11 alias
    op_simple(8'h06); op_write(16'h7F33, 8'h3C);
    op_read("R11 high bits ignored", 16'h0033, 1);

    // R9 partial byte: no commit
    op_simple(8'h06);
    sel(); xfer(8'h02, 8, r); xfer(8'h00, 8, r); xfer(8'h40, 8, r); xfer(8'hEE, 5, r); desel();
    op_rdsr("R9 partial byte no commit", 1'b0);
    op_read("R9 partial byte memory unchanged", 16'h0040, 1);
    op_simple(8'h04);

    // R4 levels
    op_simple(8'h06); op_wrsr(8'h04);
    op_rdsr("R4 level 01 stored", 1'b0);
    op_simple(8'h06); op_write(16'h00C0, 8'h11);
    op_read("R4 top quarter guarded", 16'h00C0, 1);
    op_rdsr("R4 rejected write leaves latch", 1'b0);
    op_write(16'h0080, 8'h22);
    op_read("R4 below quarter writable", 16'h0080, 1);
    op_simple(8'h06); op_wrsr(8'h08);
    op_simple(8'h06); op_write(16'h0080, 8'h33);
    op_read("R4 top half guarded", 16'h0080, 1);
    op_write(16'h007F, 8'h44);
    op_read("R4 lower half writable", 16'h007F, 1);
    op_simple(8'h06); op_wrsr(8'h0C);
    op_simple(8'h06); op_write(16'h0000, 8'h55);
    op_read("R4 all guarded", 16'h0000, 1);

    // R6 / R7
    wp_n = 1'b1;
    op_simple(8'h06); op_wrsr(8'h80);
    op_rdsr("R7 status written with pin high", 1'b0);
    wp_n = 1'b0;
    op_simple(8'h06); op_wrsr(8'h00);
    op_rdsr("R6 protect-enable locked", 1'b0);
    op_write(16'h0020, 8'h66);
    op_read("R6 unguarded write allowed", 16'h0020, 1);
    wp_n = 1'b1;
    op_simple(8'h06); op_wrsr(8'h00);
    op_rdsr("R7 unlocked by pin high", 1'b0);

    // random phase
    for (int it = 0; it < 40; it++) begin
      int op;
      op = $urandom % 6;
      wp_n = $urandom % 2;
      case (op)
        0: op_simple(8'h06);
        1: op_simple(8'h04);
        2: op_write({$urandom % 256, 8'h00} | 16'($urandom % 256), 8'($urandom));
        3: op_read("R1 R2 random read", 16'($urandom), 1 + $urandom % 3);
        4: op_wrsr(8'($urandom) & 8'h8C);
        default: op_rdsr("R5 random status", 1'b0);
      endcase
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule